// File: doc/BRIEF.md
# Two-Port Mailbox Interrupt Flags

This block produces the port-to-port interrupt flags for a two-port 2K x 9 memory. Each port owns one of the two highest addresses as its mailbox: the left port owns the word just below the top (0x7FE for the default 11-bit address) and the right port owns the top word (0x7FF). When one port writes into its partner's mailbox, the partner's interrupt goes active. When the partner then accesses its own mailbox with chip enable and output enable both low, that interrupt is cleared.

The block watches only the control and address lines of both ports. The mailbox words stay ordinary storage in the memory array outside this block, so the nine bits of the message are whatever the user writes there. A port's active-low write-inhibit (busy) input suppresses that port's raising write. A function enable turns the whole mechanism off. When it is off, both interrupts stay inactive and the two top addresses act as plain memory.

All inputs are sampled on the rising clock edge. Each flag is one register, and each interrupt output is the inverse of its flag gated by the function enable. The outputs are always driven, high or low, and are never high-impedance.

Top module: `mbox_irq_flags`

## Requirements
- R1: After reset both interrupt outputs are high (inactive).
- R2: A left-port write, meaning l_cs_n=0 and l_we_n=0 in the same cycle, to address 0x7FF while l_busy_n=1 drives r_irq_n low after the next rising edge.
- R3: A right-port write, meaning r_cs_n=0 and r_we_n=0, to address 0x7FE while r_busy_n=1 drives l_irq_n low after the next rising edge.
- R4: A mailbox write with chip enable high does not raise a flag, even when read/write is low.
- R5: The right flag clears, and r_irq_n goes high, after a cycle in which r_cs_n=0, r_oe_n=0 and r_addr=0x7FF. The level of r_we_n does not matter.
- R6: The left flag clears, and l_irq_n goes high, after a cycle in which l_cs_n=0, l_oe_n=0 and l_addr=0x7FE. The level of l_we_n does not matter.
- R7: A mailbox write made while the writing port's busy input is low leaves the partner's flag unchanged.
- R8: When a raise and a clear of the same flag fall in the same cycle, the flag ends up set.
- R9: While func_en=0, both interrupt outputs are high and mailbox accesses are not remembered. A flag that was pending when the enable dropped is gone when the enable returns.
- R10: Accesses to any other address, and mailbox accesses with output enable high and no write, leave both flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| func_en | input | 1 | Enable for the mailbox interrupt function |
| l_cs_n | input | 1 | Left chip enable, active low |
| l_oe_n | input | 1 | Left output enable, active low |
| l_we_n | input | 1 | Left read/write, low means write |
| l_busy_n | input | 1 | Left write-inhibit, low blocks the left port's writes |
| l_addr | input | 11 | Left word address |
| r_cs_n | input | 1 | Right chip enable, active low |
| r_oe_n | input | 1 | Right output enable, active low |
| r_we_n | input | 1 | Right read/write, low means write |
| r_busy_n | input | 1 | Right write-inhibit, low blocks the right port's writes |
| r_addr | input | 11 | Right word address |
| l_irq_n | output | 1 | Left interrupt, active low |
| r_irq_n | output | 1 | Right interrupt, active low |

## Verification
On every cycle the bound checker tests four things. A permitted mailbox write raises the partner's interrupt one edge later. A lone clear releases it. An inhibited write, or unrelated traffic, leaves the outputs steady. A low enable holds both outputs high. Other behaviours need sequences that only the bench's scenarios build. These are the set-over-clear priority when both events meet in one cycle, the fact that read/write is ignored during a clear, and the loss of a pending flag across a disable and re-enable. The bench's reference model is compared against both outputs on every clock.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

    // Number of ports sharing the memory; index 0 is left, 1 is right.
    localparam int PORTS = 2;

    typedef enum logic {
        SIDE_LEFT  = 1'b0,
        SIDE_RIGHT = 1'b1
    } port_side_e;

    // Control strobes of one port, all active low.
    typedef struct packed {
        logic cs_n;
        logic oe_n;
        logic we_n;
        logic busy_n;
    } port_ctl_t;

    // Registered state of the block: one pending bit per port.
    typedef struct packed {
        logic [PORTS-1:0] pend;
    } flag_state_t;

endpackage

// File: rtl/mbox_port_decode.sv
module mbox_port_decode
    import mbox_pkg::*;
#(
    parameter int                ADDR_W   = 11,
    parameter logic [ADDR_W-1:0] OWN_BOX  = '1,
    parameter logic [ADDR_W-1:0] PEER_BOX = '1
) (
    input  port_ctl_t         ctl,
    input  logic [ADDR_W-1:0] addr,
    output logic              peer_raise,
    output logic              own_drop
);

    logic selected;
    logic writing;
    logic hit_own;
    logic hit_peer;

    always_comb begin
        selected   = ~ctl.cs_n;
        writing    = selected & ~ctl.we_n;
        hit_own    = (addr == OWN_BOX);
        hit_peer   = (addr == PEER_BOX);
        // An inhibited write never reaches the partner's flag.
        peer_raise = writing & ctl.busy_n & hit_peer;
        // A clear needs the port selected with its output enabled; read/write is ignored.
        own_drop   = selected & ~ctl.oe_n & hit_own;
    end

endmodule

// File: rtl/mbox_flag_next.sv
module mbox_flag_next (
    input  logic en,
    input  logic cur,
    input  logic raise,
    input  logic drop,
    output logic nxt
);

    always_comb begin
        if (!en) begin
            nxt = 1'b0;
        end else if (raise) begin
            // A raise outranks a simultaneous clear so a message is never lost.
            nxt = 1'b1;
        end else if (drop) begin
            nxt = 1'b0;
        end else begin
            nxt = cur;
        end
    end

endmodule

// File: rtl/mbox_irq_flags.sv
module mbox_irq_flags
    import mbox_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              func_en,
    input  logic              l_cs_n,
    input  logic              l_oe_n,
    input  logic              l_we_n,
    input  logic              l_busy_n,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic              r_cs_n,
    input  logic              r_oe_n,
    input  logic              r_we_n,
    input  logic              r_busy_n,
    input  logic [ADDR_W-1:0] r_addr,
    output logic              l_irq_n,
    output logic              r_irq_n
);

    // The right port owns the top word, the left port the one below it.
    localparam logic [ADDR_W-1:0] BOX_RIGHT = '1;
    localparam logic [ADDR_W-1:0] BOX_LEFT  = BOX_RIGHT - 1'b1;

    port_ctl_t         ctl_arr  [PORTS];
    logic [ADDR_W-1:0] addr_arr [PORTS];
    logic [PORTS-1:0]  raise_peer;
    logic [PORTS-1:0]  drop_own;
    logic [PORTS-1:0]  pend_nxt;

    flag_state_t state_d;
    flag_state_t state_q;

    always_comb begin
        ctl_arr[SIDE_LEFT]   = '{cs_n: l_cs_n, oe_n: l_oe_n, we_n: l_we_n, busy_n: l_busy_n};
        ctl_arr[SIDE_RIGHT]  = '{cs_n: r_cs_n, oe_n: r_oe_n, we_n: r_we_n, busy_n: r_busy_n};
        addr_arr[SIDE_LEFT]  = l_addr;
        addr_arr[SIDE_RIGHT] = r_addr;
    end

    for (genvar p = 0; p < PORTS; p++) begin : g_port
        localparam logic [ADDR_W-1:0] OWN  = (p == 0) ? BOX_LEFT  : BOX_RIGHT;
        localparam logic [ADDR_W-1:0] PEER = (p == 0) ? BOX_RIGHT : BOX_LEFT;

        mbox_port_decode #(
            .ADDR_W   (ADDR_W),
            .OWN_BOX  (OWN),
            .PEER_BOX (PEER)
        ) u_dec (
            .ctl        (ctl_arr[p]),
            .addr       (addr_arr[p]),
            .peer_raise (raise_peer[p]),
            .own_drop   (drop_own[p])
        );

        // Port p's flag is raised by the other port and dropped by port p itself.
        mbox_flag_next u_next (
            .en    (func_en),
            .cur   (state_q.pend[p]),
            .raise (raise_peer[PORTS-1-p]),
            .drop  (drop_own[p]),
            .nxt   (pend_nxt[p])
        );
    end

    always_comb begin
        state_d      = state_q;
        state_d.pend = pend_nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    // Push-pull outputs, masked at once when the function is off.
    assign l_irq_n = ~(state_q.pend[SIDE_LEFT]  & func_en);
    assign r_irq_n = ~(state_q.pend[SIDE_RIGHT] & func_en);

endmodule

// File: rtl/mbox_irq_flags_chk.sv
module mbox_irq_flags_chk #(
    parameter int ADDR_W = 11
) (
    input logic              clk,
    input logic              rst_n,
    input logic              func_en,
    input logic              l_cs_n,
    input logic              l_oe_n,
    input logic              l_we_n,
    input logic              l_busy_n,
    input logic [ADDR_W-1:0] l_addr,
    input logic              r_cs_n,
    input logic              r_oe_n,
    input logic              r_we_n,
    input logic              r_busy_n,
    input logic [ADDR_W-1:0] r_addr,
    input logic              l_irq_n,
    input logic              r_irq_n
);

    localparam logic [ADDR_W-1:0] TOP_W  = '1;
    localparam logic [ADDR_W-1:0] NEXT_W = TOP_W - 1'b1;

    logic l_wr_box;
    logic r_wr_box;
    logic l_clr;
    logic r_clr;

    assign l_wr_box = !l_cs_n && !l_we_n && (l_addr == TOP_W);
    assign r_wr_box = !r_cs_n && !r_we_n && (r_addr == NEXT_W);
    assign r_clr    = !r_cs_n && !r_oe_n && (r_addr == TOP_W);
    assign l_clr    = !l_cs_n && !l_oe_n && (l_addr == NEXT_W);

    p_reset_idle_r1: assert property (@(posedge clk) !rst_n |=> (l_irq_n && r_irq_n) || !rst_n);

    p_raise_right_r2: assert property (@(posedge clk) disable iff (!rst_n)
        func_en && l_wr_box && l_busy_n |=> !r_irq_n || !func_en);

    p_raise_left_r3: assert property (@(posedge clk) disable iff (!rst_n)
        func_en && r_wr_box && r_busy_n |=> !l_irq_n || !func_en);

    p_clear_right_r5: assert property (@(posedge clk) disable iff (!rst_n)
        r_clr && !(l_wr_box && l_busy_n) |=> r_irq_n);

    p_clear_left_r6: assert property (@(posedge clk) disable iff (!rst_n)
        l_clr && !(r_wr_box && r_busy_n) |=> l_irq_n);

    p_inhibit_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        func_en && l_wr_box && !l_busy_n && !r_clr |=> $stable(r_irq_n) || !func_en);

    p_disabled_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !func_en |-> l_irq_n && r_irq_n);

    p_unrelated_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(l_wr_box && l_busy_n) && !r_clr && !(r_wr_box && r_busy_n) && !l_clr
        |=> ($stable(r_irq_n) && $stable(l_irq_n)) || !func_en || !$past(func_en));

endmodule

bind mbox_irq_flags mbox_irq_flags_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/mbox_irq_flags_bench.sv
module mbox_irq_flags_bench;

    localparam int AW = 11;
    localparam logic [AW-1:0] A_TOP  = 11'h7FF;
    localparam logic [AW-1:0] A_NEXT = 11'h7FE;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic func_en = 1'b1;
    logic l_cs_n = 1'b1, l_oe_n = 1'b1, l_we_n = 1'b1, l_busy_n = 1'b1;
    logic r_cs_n = 1'b1, r_oe_n = 1'b1, r_we_n = 1'b1, r_busy_n = 1'b1;
    logic [AW-1:0] l_addr = '0;
    logic [AW-1:0] r_addr = '0;
    logic l_irq_n, r_irq_n;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    bit m_left = 1'b0;
    bit m_right = 1'b0;

    always #10 clk = ~clk;

    mbox_irq_flags #(.ADDR_W(AW)) u_mbox_irq_flags (
        .clk(clk), .rst_n(rst_n), .func_en(func_en),
        .l_cs_n(l_cs_n), .l_oe_n(l_oe_n), .l_we_n(l_we_n), .l_busy_n(l_busy_n), .l_addr(l_addr),
        .r_cs_n(r_cs_n), .r_oe_n(r_oe_n), .r_we_n(r_we_n), .r_busy_n(r_busy_n), .r_addr(r_addr),
        .l_irq_n(l_irq_n), .r_irq_n(r_irq_n)
    );

    task automatic compare(input string tag);
        bit exp_l;
        bit exp_r;
        exp_l = !(m_left && func_en);
        exp_r = !(m_right && func_en);
        checks++;
        if (l_irq_n !== exp_l) begin
            failures++;
            $display("FAIL %s l_irq_n actual=%b expected=%b", tag, l_irq_n, exp_l);
        end
        checks++;
        if (r_irq_n !== exp_r) begin
            failures++;
            $display("FAIL %s r_irq_n actual=%b expected=%b", tag, r_irq_n, exp_r);
        end
    endtask

    // One cycle: ports given as {cs_n, oe_n, we_n, busy_n}.
    task automatic step(input logic [3:0] lc, input logic [AW-1:0] la,
                        input logic [3:0] rc, input logic [AW-1:0] ra,
                        input logic en, input string tag);
        bit l_set, r_set, l_drop, r_drop;
        {l_cs_n, l_oe_n, l_we_n, l_busy_n} = lc;
        {r_cs_n, r_oe_n, r_we_n, r_busy_n} = rc;
        l_addr = la;
        r_addr = ra;
        func_en = en;
        @(posedge clk);
        r_set  = (lc[3] == 0) && (lc[1] == 0) && (lc[0] == 1) && (la == A_TOP);
        l_set  = (rc[3] == 0) && (rc[1] == 0) && (rc[0] == 1) && (ra == A_NEXT);
        r_drop = (rc[3] == 0) && (rc[2] == 0) && (ra == A_TOP);
        l_drop = (lc[3] == 0) && (lc[2] == 0) && (la == A_NEXT);
        if (!en) begin
            m_left = 0;
            m_right = 0;
        end else begin
            if (l_set) m_left = 1; else if (l_drop) m_left = 0;
            if (r_set) m_right = 1; else if (r_drop) m_right = 0;
        end
        @(negedge clk);
        compare(tag);
    endtask

    localparam logic [3:0] IDLE = 4'b1111;
    localparam logic [3:0] WR   = 4'b0101;
    localparam logic [3:0] WRB  = 4'b0100;
    localparam logic [3:0] RD   = 4'b0011;
    localparam logic [3:0] RDX  = 4'b0111;
    localparam logic [3:0] WRO  = 4'b0001;
    localparam logic [3:0] NCS  = 4'b1001;

    initial begin
        #(20 * 200000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        compare("R1 in reset");
        rst_n = 1'b1;
        step(IDLE, '0, IDLE, '0, 1, "R1 after reset");
        step(WR, A_TOP, IDLE, '0, 1, "R2 left writes right box");
        step(WR, 11'h123, IDLE, 11'h7FD, 1, "R10 other address");
        step(IDLE, '0, RDX, A_TOP, 1, "R10 oe high no clear");
        step(IDLE, '0, WRO, A_TOP, 1, "R5 clear with we low");
        step(IDLE, '0, WR, A_NEXT, 1, "R3 right writes left box");
        step(RD, A_NEXT, IDLE, '0, 1, "R6 left clear read");
        step(IDLE, '0, NCS, A_NEXT, 1, "R4 cs high no raise");
        step(NCS, A_TOP, IDLE, '0, 1, "R4 left cs high no raise");
        step(WRB, A_TOP, IDLE, '0, 1, "R7 busy blocks raise");
        step(IDLE, '0, WRB, A_NEXT, 1, "R7 right busy blocks raise");
        step(WR, A_TOP, WR, A_NEXT, 1, "R2 R3 both raise");
        step(WRB, A_TOP, IDLE, '0, 1, "R7 busy keeps set flag");
        step(WR, A_TOP, RD, A_TOP, 1, "R8 set beats clear right");
        step(RD, A_NEXT, WR, A_NEXT, 1, "R8 set beats clear left");
        step(IDLE, '0, RD, A_TOP, 1, "R5 clear read");
        step(RD, A_NEXT, IDLE, '0, 1, "R6 clear after priority");
        step(WR, A_TOP, IDLE, '0, 0, "R9 disabled write ignored");
        step(IDLE, '0, IDLE, '0, 1, "R9 not remembered");
        step(WR, A_TOP, WR, A_NEXT, 1, "R2 raise before disable");
        step(IDLE, '0, IDLE, '0, 0, "R9 outputs high when off");
        step(IDLE, '0, IDLE, '0, 1, "R9 pending lost");
        step(RD, A_NEXT, RD, A_TOP, 1, "R10 clear with none pending");
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule